// File: doc/BRIEF.md
# Indirect Command/Data Register Port

This block sits between a processor's programmed-I/O bus and two independent controller halves. The processor reaches each half through a pair of 16-bit ports: a command port and a data port. To touch a register, software first writes a command code to a half's command port. The low seven bits of that code name the register, and bit 7 says whether the following data accesses may write it. Software then reads or writes the value through the same half's data port. Each half remembers its last command, so repeated data accesses reuse it.

The bus is sampled on the block clock. One port access is decoded from chip select, two address lines and two active-low strobes. A read result appears on `rdata` with a one-cycle `rd_valid` pulse. There is no back-pressure: the bus cannot be stalled, so the processor must take the value while `rd_valid` is high. `rdata` keeps that value until the next read. Each half holds a small window of registers, by default at indices 0x20 to 0x27. For example, code 0x21 selects register 0x21 for reading, and 0xA1 selects it for reading and writing.

Top module: `pio_cmd_port_top`

## Requirements
- R1: After reset, `rdata` is 0x0000, `rd_valid` is low, both latched commands are 0x00 and every register holds 0x0000.
- R2: While `cs_n` is high, no strobe edge has any effect: no register or command changes and `rd_valid` stays low.
- R3: With `cs_n` low, `addr` selects the port: 0 is the first half's data port, 1 its command port, 2 the second half's data port and 3 its command port.
- R4: A write to a command port latches `wdata[7:0]` for that half and ignores `wdata[15:8]`. Bit 7 is the write permission and bits 6:0 are the register index. The latched command stays in force for any number of later data accesses.
- R5: A data-port read returns the register named by the latched index. `rdata` updates and `rd_valid` pulses for one cycle on the clock edge that samples the strobe's falling edge, and `rdata` then holds until the next read.
- R6: A data-port write stores `wdata` into the indexed register only when the latched command has bit 7 set; otherwise the write is ignored.
- R7: A read aimed at a command port returns 0x0000 with `rd_valid` and changes no state.
- R8: An index outside the window [REG_BASE, REG_BASE+REG_COUNT) reads as 0x0000 and ignores writes. Both window edges are included or excluded as the interval states.
- R9: Each low pulse of `rd_n` or `wr_n` is exactly one access, taken at its falling edge. A strobe held low, or bus data that changes while it is low, causes no further access.
- R10: The two halves are independent. Commands and registers of one half are never changed by accesses to the other.
- R11: If `rd_n` and `wr_n` fall in the same sampled cycle, the access is discarded and nothing changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all bus inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| addr | input | 2 | Port select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| wdata | input | 16 | Write data from the processor |
| rdata | output | 16 | Read result, held until the next read |
| rd_valid | output | 1 | One-cycle pulse marking a new read result |

## Verification
The access sequences cover both halves with commands that do and do not carry the write bit. This separates a gated write from an ignored one, and shows that one half's registers do not leak into the other's. Indices just inside and just outside each edge of the register window separate correct window decoding from an off-by-one error. Command codes with junk in the upper byte show that only the low byte is latched. Directed cases hold a strobe low while the data changes, let both strobes fall together, and toggle strobes with chip select high. These cases tell edge detection apart from level detection and show that collisions and deselected cycles are dropped.

// File: rtl/pio_port_pkg.sv
package pio_port_pkg;

  typedef enum logic [1:0] {
    PORT_A_DATA = 2'd0,
    PORT_A_CMD  = 2'd1,
    PORT_B_DATA = 2'd2,
    PORT_B_CMD  = 2'd3
  } port_sel_e;

  typedef struct packed {
    logic      rd;
    logic      wr;
    port_sel_e port;
  } bus_evt_t;

  localparam int unsigned CMD_W  = 8;
  localparam int unsigned IDX_W  = 7;
  localparam int unsigned WR_BIT = 7;

endpackage

// File: rtl/pio_strobe_decode.sv
module pio_strobe_decode
  import pio_port_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic [1:0] addr,
  input  logic       rd_n,
  input  logic       wr_n,
  output bus_evt_t   evt
);

  logic rd_prev_q, wr_prev_q;
  logic rd_fall, wr_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_prev_q <= 1'b1;
      wr_prev_q <= 1'b1;
    end else begin
      rd_prev_q <= rd_n;
      wr_prev_q <= wr_n;
    end
  end

  assign rd_fall = rd_prev_q & ~rd_n;
  assign wr_fall = wr_prev_q & ~wr_n;

  always_comb begin
    evt.port = port_sel_e'(addr);
    evt.rd   = ~cs_n & rd_fall & ~wr_fall;
    evt.wr   = ~cs_n & wr_fall & ~rd_fall;
  end

  // R2: a deselected bus never produces an access
  p_no_access_deselected_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !(evt.rd || evt.wr));

  // R11: read and write events never coexist
  p_single_event_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({evt.rd, evt.wr}));

  // R9: an event needs the strobe high in the previous cycle
  p_edge_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.rd || evt.wr) |=> !(evt.rd || evt.wr) || ($past(evt.rd) != evt.rd));

endmodule

// File: rtl/pio_half_regs.sv
module pio_half_regs
  import pio_port_pkg::*;
#(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned REG_BASE  = 32,
  parameter int unsigned REG_COUNT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we,
  input  logic              data_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_value
);

  localparam int unsigned SLOT_W = (REG_COUNT > 1) ? $clog2(REG_COUNT) : 1;

  logic [CMD_W-1:0]                  cmd_q;
  logic [REG_COUNT-1:0][DATA_W-1:0]  regs_q;
  logic [IDX_W-1:0]                  idx, rel;
  logic [SLOT_W-1:0]                 slot;
  logic                              hit;
  logic                              store;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmd_q <= '0;
    else if (cmd_we) cmd_q <= wdata[CMD_W-1:0];
  end

  assign idx   = cmd_q[IDX_W-1:0];
  assign rel   = idx - IDX_W'(REG_BASE);
  assign hit   = rel < IDX_W'(REG_COUNT);
  assign slot  = rel[SLOT_W-1:0];
  assign store = data_we & cmd_q[WR_BIT] & hit;

  genvar g;
  generate
    for (g = 0; g < REG_COUNT; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              regs_q[g] <= '0;
        else if (store && slot == SLOT_W'(g))    regs_q[g] <= wdata;
      end
    end
  endgenerate

  assign rd_value = hit ? regs_q[slot] : '0;

  // R4: command updates only on a command write and takes the low byte
  p_cmd_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_we |=> $stable(cmd_q));
  p_cmd_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we |=> cmd_q == $past(wdata[CMD_W-1:0]));

  // R6: registers change only on a data write under a write-enabled command
  p_reg_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(data_we && cmd_q[WR_BIT]) |=> $stable(regs_q));

  // R8: an index outside the window reads as zero
  p_out_of_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> rd_value == '0);

endmodule

// File: rtl/pio_cmd_port_top.sv
module pio_cmd_port_top
  import pio_port_pkg::*;
#(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned REG_BASE  = 32,
  parameter int unsigned REG_COUNT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic [1:0]        addr,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rd_valid
);

  localparam int unsigned HALVES = 2;

  bus_evt_t                        evt;
  logic [HALVES-1:0]               cmd_we, data_we;
  logic [HALVES-1:0][DATA_W-1:0]   half_val;
  logic [DATA_W-1:0]               rdata_q;
  logic                            rd_valid_q;

  pio_strobe_decode u_decode (
    .clk   (clk),
    .rst_n (rst_n),
    .cs_n  (cs_n),
    .addr  (addr),
    .rd_n  (rd_n),
    .wr_n  (wr_n),
    .evt   (evt)
  );

  genvar h;
  generate
    for (h = 0; h < HALVES; h++) begin : g_half
      assign cmd_we[h]  = evt.wr && (evt.port == port_sel_e'(2 * h + 1));
      assign data_we[h] = evt.wr && (evt.port == port_sel_e'(2 * h));

      pio_half_regs #(
        .DATA_W    (DATA_W),
        .REG_BASE  (REG_BASE),
        .REG_COUNT (REG_COUNT)
      ) u_half (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_we   (cmd_we[h]),
        .data_we  (data_we[h]),
        .wdata    (wdata),
        .rd_value (half_val[h])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q    <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      rd_valid_q <= evt.rd;
      if (evt.rd) rdata_q <= evt.port[0] ? '0 : half_val[evt.port[1]];
    end
  end

  assign rdata    = rdata_q;
  assign rd_valid = rd_valid_q;

  // R5: a result is flagged only after a decoded read
  p_valid_after_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(evt.rd));
  // R5: read data holds between reads
  p_rdata_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> $stable(rdata));
  // R7: a command-port read yields zero
  p_cmd_read_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && $past(evt.port[0])) |-> rdata == '0);
  // R10: at most one half is written per cycle
  p_one_half_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_we, data_we}));

endmodule

// File: tb/tb_pio_cmd_port_top.sv
module tb_pio_cmd_port_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic [1:0]  addr = 2'd0;
  logic        rd_n = 1'b1;
  logic        wr_n = 1'b1;
  logic [15:0] wdata = 16'h0;
  logic [15:0] rdata;
  logic        rd_valid;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pio_cmd_port_top dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .addr(addr),
    .rd_n(rd_n), .wr_n(wr_n), .wdata(wdata),
    .rdata(rdata), .rd_valid(rd_valid)
  );

  // entry: {req[3:0], is_read, port[1:0], data[15:0], expected[15:0]}
  localparam int NV = 29;
  localparam logic [38:0] VEC [NV] = '{
    {4'd0,  1'b0, 2'd1, 16'h00A1, 16'h0},
    {4'd0,  1'b0, 2'd0, 16'h1234, 16'h0},
    {4'd0,  1'b0, 2'd1, 16'h0021, 16'h0},
    {4'd5,  1'b1, 2'd0, 16'h0,    16'h1234},  // R5 read back
    {4'd0,  1'b0, 2'd3, 16'h00A2, 16'h0},
    {4'd0,  1'b0, 2'd2, 16'hBEEF, 16'h0},
    {4'd0,  1'b0, 2'd3, 16'h0022, 16'h0},
    {4'd3,  1'b1, 2'd2, 16'h0,    16'hBEEF},  // R3 second half data port
    {4'd0,  1'b0, 2'd1, 16'h0022, 16'h0},
    {4'd10, 1'b1, 2'd0, 16'h0,    16'h0000},  // R10 half A reg 0x22 untouched
    {4'd0,  1'b0, 2'd1, 16'h0021, 16'h0},
    {4'd0,  1'b0, 2'd0, 16'h5555, 16'h0},
    {4'd6,  1'b1, 2'd0, 16'h0,    16'h1234},  // R6 write without bit 7 ignored
    {4'd0,  1'b0, 2'd1, 16'h00A7, 16'h0},
    {4'd0,  1'b0, 2'd0, 16'hFFFF, 16'h0},
    {4'd8,  1'b1, 2'd0, 16'h0,    16'hFFFF},  // R8 top window slot
    {4'd0,  1'b0, 2'd1, 16'h00A8, 16'h0},
    {4'd0,  1'b0, 2'd0, 16'h7777, 16'h0},
    {4'd8,  1'b1, 2'd0, 16'h0,    16'h0000},  // R8 just above window
    {4'd0,  1'b0, 2'd1, 16'h009F, 16'h0},
    {4'd0,  1'b0, 2'd0, 16'h1111, 16'h0},
    {4'd8,  1'b1, 2'd0, 16'h0,    16'h0000},  // R8 just below window
    {4'd0,  1'b0, 2'd1, 16'hFF21, 16'h0},
    {4'd4,  1'b1, 2'd0, 16'h0,    16'h1234},  // R4 upper byte ignored
    {4'd7,  1'b1, 2'd1, 16'h0,    16'h0000},  // R7 command port read
    {4'd7,  1'b1, 2'd3, 16'h0,    16'h0000},  // R7 command port read
    {4'd7,  1'b1, 2'd0, 16'h0,    16'h1234},  // R7 command kept
    {4'd0,  1'b0, 2'd3, 16'h0022, 16'h0},
    {4'd10, 1'b1, 2'd2, 16'h0,    16'hBEEF}   // R10 half B intact
  };

  task automatic check(input int req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] port, input logic [15:0] d);
    @(negedge clk);
    cs_n = 1'b0; addr = port; wdata = d; wr_n = 1'b0;
    @(negedge clk);
    wr_n = 1'b1; cs_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic bus_read(input logic [1:0] port, output logic [15:0] d, output logic v);
    @(negedge clk);
    cs_n = 1'b0; addr = port; rd_n = 1'b0;
    @(negedge clk);
    d = rdata; v = rd_valid;
    rd_n = 1'b1; cs_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    logic [15:0] d;
    logic v;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(1, {15'h0, rd_valid}, 16'h0);
    check(1, rdata, 16'h0000);
    rst_n = 1'b1;
    bus_read(2'd0, d, v);
    check(1, d, 16'h0000);
    check(1, {15'h0, v}, 16'h1);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][34]) begin
        bus_read(VEC[i][33:32], d, v);
        check(int'(VEC[i][38:35]), d, VEC[i][15:0]);
        check(int'(VEC[i][38:35]), {15'h0, v}, 16'h1);
      end else begin
        bus_write(VEC[i][33:32], VEC[i][31:16]);
      end
    end

    // R2 deselected strobes do nothing
    bus_write(2'd1, 16'h00A1);
    @(negedge clk); cs_n = 1'b1; addr = 2'd0; wdata = 16'hDEAD; wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1;
    @(negedge clk); rd_n = 1'b0;
    @(negedge clk); check(2, {15'h0, rd_valid}, 16'h0); rd_n = 1'b1;
    bus_read(2'd0, d, v);
    check(2, d, 16'h1234);

    // R9 held write strobe with changing data
    @(negedge clk); cs_n = 1'b0; addr = 2'd0; wdata = 16'h0F0F; wr_n = 1'b0;
    @(negedge clk); wdata = 16'hF0F0;
    @(negedge clk); @(negedge clk); wr_n = 1'b1; cs_n = 1'b1;
    bus_read(2'd0, d, v);
    check(9, d, 16'h0F0F);
    // R9 held read strobe gives one valid pulse
    @(negedge clk); cs_n = 1'b0; addr = 2'd0; rd_n = 1'b0;
    @(negedge clk); check(9, {15'h0, rd_valid}, 16'h1);
    @(negedge clk); check(9, {15'h0, rd_valid}, 16'h0);
    rd_n = 1'b1; cs_n = 1'b1;
    @(negedge clk);
    // R5 data holds after the pulse
    check(5, rdata, 16'h0F0F);

    // R11 simultaneous strobe fall is dropped
    @(negedge clk); cs_n = 1'b0; addr = 2'd0; wdata = 16'h4444; rd_n = 1'b0; wr_n = 1'b0;
    @(negedge clk); check(11, {15'h0, rd_valid}, 16'h0);
    rd_n = 1'b1; wr_n = 1'b1; cs_n = 1'b1;
    bus_read(2'd0, d, v);
    check(11, d, 16'h0F0F);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule